// File: doc/BRIEF.md
# Half-Bridge Output Ramp Sequencer

This block takes one half-bridge output channel through start-up and shut-down. When the ramp strap is set, the output level sweeps from ground up to the mid-supply bias point before normal PWM is let through. On shut-down it sweeps back down to ground, and only then does the output go high-impedance. The ramp level is a digital code that an analog stage downstream turns into a voltage. That code moves by one step every `STEP_DIV` clocks and stops exactly at 0 and at `LEVEL_MAX`.

When the strap is clear, no ramp is used. Normal switching starts after `START_CYC` rising edges of the incoming PWM, and the output drops to high-impedance as soon as the channel reset goes low. A ramp in either direction can be turned around part way: the level then moves back from the value it has reached.

The PWM input is asynchronous and passes through a two-flop synchronizer. An activity timer tracks whether the input is still toggling. A waiting channel never starts while its PWM input is idle.

Top module: `hb_ramp_seq`

## Requirements
- R1: While `ch_rst_ni` is low and no ramp-down is in progress, `hiz_o`=1, `pwm_pass_o`=0 and `ramp_active_o`=0. The level is 0 after a ramp-down completes, after system reset, and throughout ramp-disabled operation.
- R2: With `ramp_en_i`=1 and `ch_rst_ni` high, a ramp-up (`ramp_active_o`=1, `hiz_o`=0) begins only after a synchronized rising edge of `pwm_i` has been seen. Until then, `hiz_o` stays 1.
- R3: During ramp-up, `level_o` rises by exactly 1 every `STEP_DIV` clocks and never exceeds `LEVEL_MAX`. `pwm_pass_o` goes high one clock after `level_o` reaches `LEVEL_MAX`, and never earlier.
- R4: With `ramp_en_i`=0, `pwm_pass_o` goes high one clock after the `START_CYC`-th synchronized rising edge of `pwm_i` following release of `ch_rst_ni`. `level_o` stays 0 and `ramp_active_o` stays 0.
- R5: With `ramp_en_i`=1, taking `ch_rst_ni` low while running starts a ramp-down. `level_o` falls by 1 every `STEP_DIV` clocks, `hiz_o` stays 0 while it falls, and `hiz_o` rises one clock after `level_o` reaches 0.
- R6: With `ramp_en_i`=0, taking `ch_rst_ni` low while running sets `hiz_o`=1 and `pwm_pass_o`=0 at the next clock edge.
- R7: When `ch_rst_ni` goes high during a ramp-down, the ramp turns upward from the current level without passing through high-impedance. When `ch_rst_ni` goes low during a ramp-up, the ramp turns downward from the current level. `level_o` never changes by more than 1 in a clock.
- R8: A rising edge of `pwm_i` first sampled at clock edge k takes effect as a rising event at edge k+2. With ramping enabled, `ramp_active_o` is therefore set from edge k+3.
- R9: The PWM input counts as active for `IDLE_TO` clocks after each synchronized rising edge. A waiting channel with an idle input does not start. With ramping disabled, the edge count restarts from zero once the input has been idle for longer than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| ramp_en_i | input | 1 | Ramp strap: 1 = ramp up and down, 0 = counted start and immediate stop |
| ch_rst_ni | input | 1 | Active-low channel reset, synchronous to clk_i |
| pwm_i | input | 1 | Asynchronous PWM input from the modulator |
| hiz_o | output | 1 | 1 = output stage high-impedance |
| ramp_active_o | output | 1 | 1 while a ramp-up or ramp-down is in progress |
| level_o | output | $clog2(LEVEL_MAX+1) | Ramp level code, 0 = ground, LEVEL_MAX = bias point |
| pwm_pass_o | output | 1 | 1 = normal PWM is passed to the gate drive |

## Verification
The hardest situation to reach from the ports is a ramp reversal in mid-sweep, made harder when the reversal coincides with a step-divider tick. The stimulus gets there by waiting on `level_o` for a chosen mid-scale value and then toggling the channel reset, first one way and then the other. A behavioural model compared every clock then pins down the level trajectory across the turn. A second hard case is the idle-input restart of the start count: the bench lets several edges pass, halts the PWM for longer than the timeout, and resumes it. This shows that the start comes `START_CYC` edges after the resume, and not earlier.

// File: rtl/hb_ramp_seq_pkg.sv
package hb_ramp_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WAIT = 3'd1,
    ST_UP   = 3'd2,
    ST_RUN  = 3'd3,
    ST_DOWN = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pwm_activity.sv
module pwm_activity #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_TO     = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic rise_o,
  output logic active_o
);
  localparam int TMR_W = $clog2(IDLE_TO + 1);

  logic [SYNC_STAGES:0] sh_q;
  logic [TMR_W-1:0]     tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q[0] <= 1'b0;
    else         sh_q[0] <= pwm_i;
  end

  // synchronizer stages plus one edge-detect stage
  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[i] <= 1'b0;
      else         sh_q[i] <= sh_q[i-1];
    end
  end

  assign rise_o   = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign active_o = (tmr_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tmr_q <= '0;
    else if (rise_o)      tmr_q <= TMR_W'(IDLE_TO);
    else if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
  end

  // R8
  rise_arms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> active_o);

  // R9
  idle_decay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_o && !active_o) |=> !active_o);
endmodule

// File: rtl/ramp_level.sv
module ramp_level #(
  parameter int LEVEL_MAX = 16,
  parameter int STEP_DIV  = 4,
  localparam int LVL_W    = $clog2(LEVEL_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  output logic [LVL_W-1:0] level_o,
  output logic             at_top_o,
  output logic             at_bot_o
);
  localparam int DIV_W = $clog2(STEP_DIV + 1);

  logic [DIV_W-1:0] div_q;
  logic [LVL_W-1:0] lvl_q;
  logic             tick;

  assign tick     = en_i && (div_q == DIV_W'(STEP_DIV - 1));
  assign at_top_o = (lvl_q == LVL_W'(LEVEL_MAX));
  assign at_bot_o = (lvl_q == '0);
  assign level_o  = lvl_q;

  // divider keeps phase across a direction change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= '0;
    else if (!en_i) div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else if (tick) begin
      if (up_i && !at_top_o)      lvl_q <= lvl_q + 1'b1;
      else if (!up_i && !at_bot_o) lvl_q <= lvl_q - 1'b1;
    end
  end

  // R3
  level_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LVL_W'(LEVEL_MAX));

  // R7
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |->
      ((lvl_q == $past(lvl_q) + 1'b1) || (lvl_q == $past(lvl_q) - 1'b1)));

  // R1
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> $stable(lvl_q));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import hb_ramp_seq_pkg::*;
#(
  parameter int LEVEL_MAX = 16,
  parameter int START_CYC = 35,
  localparam int LVL_W    = $clog2(LEVEL_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ramp_en_i,
  input  logic             ch_rst_ni,
  input  logic             rise_i,
  input  logic             active_i,
  input  logic             at_top_i,
  input  logic             at_bot_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             ramp_on_o,
  output logic             ramp_up_o,
  output logic             hiz_o,
  output logic             ramp_active_o,
  output logic             pwm_pass_o
);
  localparam int CNT_W = $clog2(START_CYC + 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_done;

  assign cnt_done = rise_i && (cnt_q == CNT_W'(START_CYC - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:  if (ch_rst_ni) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!ch_rst_ni)                 st_d = ST_OFF;
        else if (ramp_en_i && active_i) st_d = ST_UP;
        else if (!ramp_en_i && cnt_done) st_d = ST_RUN;
      end
      ST_UP: begin
        if (!ch_rst_ni)    st_d = ST_DOWN;
        else if (at_top_i) st_d = ST_RUN;
      end
      ST_RUN:  if (!ch_rst_ni) st_d = ramp_en_i ? ST_DOWN : ST_OFF;
      ST_DOWN: begin
        if (ch_rst_ni)     st_d = ST_UP;
        else if (at_bot_i) st_d = ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  // start-edge counter, cleared by an idle input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (st_q != ST_WAIT || ramp_en_i) cnt_q <= '0;
    else if (rise_i)                     cnt_q <= cnt_q + 1'b1;
    else if (!active_i)                  cnt_q <= '0;
  end

  assign ramp_on_o     = (st_q == ST_UP) || (st_q == ST_DOWN);
  assign ramp_up_o     = (st_q == ST_UP);
  assign hiz_o         = (st_q == ST_OFF) || (st_q == ST_WAIT);
  assign ramp_active_o = ramp_on_o;
  assign pwm_pass_o    = (st_q == ST_RUN);

  // R1
  hiz_blocks_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_o |-> !pwm_pass_o);

  // R3
  pass_at_bias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwm_pass_o) && $past(ramp_active_o)) |-> (level_i == LVL_W'(LEVEL_MAX)));

  // R5
  hiz_after_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hiz_o) && $past(ramp_active_o)) |-> ($past(level_i) == '0));

  // R6
  hard_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ch_rst_ni && !ramp_en_i && !ramp_active_o) |-> hiz_o);

  // R2
  wait_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ramp_active_o) && $past(hiz_o)) |-> $past(active_i));
endmodule

// File: rtl/hb_ramp_seq.sv
module hb_ramp_seq #(
  parameter int LEVEL_MAX = 16,
  parameter int STEP_DIV  = 4,
  parameter int START_CYC = 35,
  parameter int IDLE_TO   = 64,
  localparam int LVL_W    = $clog2(LEVEL_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ramp_en_i,
  input  logic             ch_rst_ni,
  input  logic             pwm_i,
  output logic             hiz_o,
  output logic             ramp_active_o,
  output logic [LVL_W-1:0] level_o,
  output logic             pwm_pass_o
);
  logic rise, active, at_top, at_bot, ramp_on, ramp_up;

  pwm_activity #(.SYNC_STAGES(2), .IDLE_TO(IDLE_TO)) u_act (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i),
    .rise_o(rise), .active_o(active)
  );

  ramp_level #(.LEVEL_MAX(LEVEL_MAX), .STEP_DIV(STEP_DIV)) u_lvl (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ramp_on), .up_i(ramp_up),
    .level_o(level_o), .at_top_o(at_top), .at_bot_o(at_bot)
  );

  seq_fsm #(.LEVEL_MAX(LEVEL_MAX), .START_CYC(START_CYC)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .ramp_en_i(ramp_en_i), .ch_rst_ni(ch_rst_ni),
    .rise_i(rise), .active_i(active), .at_top_i(at_top), .at_bot_i(at_bot),
    .level_i(level_o), .ramp_on_o(ramp_on), .ramp_up_o(ramp_up),
    .hiz_o(hiz_o), .ramp_active_o(ramp_active_o), .pwm_pass_o(pwm_pass_o)
  );
endmodule

// File: tb/sim_hb_ramp_seq.sv
module sim_hb_ramp_seq;
  localparam int LM = 16, SD = 4, SC = 35, IT = 64;
  localparam int LW = $clog2(LM + 1);

  logic clk = 1'b0, rst_ni = 1'b0, ramp_en = 1'b1, ch_rst_n = 1'b0, pwm = 1'b0;
  logic hiz, ract, pass;
  logic [LW-1:0] lvl;
  int checks = 0, errors = 0;
  bit pwm_run = 1'b0;
  int phase = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_ramp_seq #(.LEVEL_MAX(LM), .STEP_DIV(SD), .START_CYC(SC), .IDLE_TO(IT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ramp_en_i(ramp_en), .ch_rst_ni(ch_rst_n),
    .pwm_i(pwm), .hiz_o(hiz), .ramp_active_o(ract), .level_o(lvl), .pwm_pass_o(pass)
  );

  // behavioural reference: 0 off, 1 wait, 2 up, 3 run, 4 down
  int m_st = 0, m_lvl = 0, m_div = 0, m_tmr = 0, m_cnt = 0;
  bit p1 = 0, p2 = 0, p3 = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_lvl = 0; m_div = 0; m_tmr = 0; m_cnt = 0;
      p1 = 0; p2 = 0; p3 = 0;
    end else begin
      bit rise, act;
      int o_st, o_lvl, o_cnt;
      rise = p2 && !p3;
      act  = (m_tmr > 0);
      o_st = m_st; o_lvl = m_lvl; o_cnt = m_cnt;
      if (o_st == 2 || o_st == 4) begin
        if (m_div == SD - 1) begin
          m_div = 0;
          if (o_st == 2 && m_lvl < LM) m_lvl++;
          else if (o_st == 4 && m_lvl > 0) m_lvl--;
        end else m_div++;
      end else m_div = 0;
      case (o_st)
        0: if (ch_rst_n) m_st = 1;
        1: if (!ch_rst_n) m_st = 0;
           else if (ramp_en && act) m_st = 2;
           else if (!ramp_en && rise && o_cnt == SC - 1) m_st = 3;
        2: if (!ch_rst_n) m_st = 4; else if (o_lvl == LM) m_st = 3;
        3: if (!ch_rst_n) m_st = ramp_en ? 4 : 0;
        4: if (ch_rst_n) m_st = 2; else if (o_lvl == 0) m_st = 0;
        default: m_st = 0;
      endcase
      if (o_st != 1 || ramp_en) m_cnt = 0;
      else if (rise) m_cnt = o_cnt + 1;
      else if (!act) m_cnt = 0;
      if (rise) m_tmr = IT; else if (m_tmr > 0) m_tmr--;
      p3 = p2; p2 = p1; p1 = pwm;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      bit e_hiz, e_ract, e_pass;
      e_hiz  = (m_st <= 1);
      e_ract = (m_st == 2 || m_st == 4);
      e_pass = (m_st == 3);
      checks++;
      if (hiz !== e_hiz) begin errors++;
        $display("FAIL R1 model hiz_o actual=%0b expected=%0b t=%0t", hiz, e_hiz, $time); end
      if (ract !== e_ract) begin errors++;
        $display("FAIL R2 model ramp_active_o actual=%0b expected=%0b t=%0t", ract, e_ract, $time); end
      if (pass !== e_pass) begin errors++;
        $display("FAIL R3 model pwm_pass_o actual=%0b expected=%0b t=%0t", pass, e_pass, $time); end
      if (int'(lvl) !== m_lvl) begin errors++;
        $display("FAIL R7 model level_o actual=%0d expected=%0d t=%0t", lvl, m_lvl, $time); end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      if (pwm_run) begin
        if (phase == 2) begin pwm = ~pwm; phase = 0; end
        else phase++;
      end
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    #1;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_pass(int lim);
    for (int i = 0; i < lim && !pass; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 hiz after reset", hiz, 1);
    chk("R1 pass after reset", pass, 0);
    chk("R1 level after reset", lvl, 0);
    chk("R1 ramp_active after reset", ract, 0);

    // R9 / R2: released but idle input -> no start
    ch_rst_n = 1'b1;
    step(100);
    chk("R9 idle input keeps hiz", hiz, 1);
    chk("R2 no ramp without edge", ract, 0);

    // R8: latency of a single edge
    pwm = 1'b1; phase = 0;
    step(3);
    chk("R8 ramp not yet active", ract, 0);
    step(1);
    chk("R8 ramp active at k+3", ract, 1);
    pwm_run = 1'b1;

    wait_pass(200);
    chk("R3 level at bias when passing", lvl, LM);
    chk("R3 pass reached", pass, 1);

    // R5 ramp down
    ch_rst_n = 1'b0;
    step(2);
    chk("R5 ramping down", ract, 1);
    chk("R5 not hiz during ramp-down", hiz, 0);
    step(LM * SD + 4);
    chk("R5 hiz after ramp-down", hiz, 1);
    chk("R1 level zero after ramp-down", lvl, 0);

    // R7 reversal
    ch_rst_n = 1'b1;
    for (int i = 0; i < 300 && lvl != 8; i++) step();
    chk("R7 reached mid level", lvl, 8);
    ch_rst_n = 1'b0;
    step(3 * SD);
    chk("R7 reversed downward", int'(lvl < 8), 1);
    chk("R7 no hiz in reversal", hiz, 0);
    ch_rst_n = 1'b1;
    step(2);
    chk("R7 no hiz after upturn", hiz, 0);
    wait_pass(200);
    chk("R7 resumed to bias", lvl, LM);
    ch_rst_n = 1'b0;
    step(LM * SD + 6);
    chk("R5 down done", hiz, 1);

    // R4 ramp disabled start
    ramp_en = 1'b0;
    step(2);
    ch_rst_n = 1'b1;
    step(20);
    chk("R4 not started early", pass, 0);
    wait_pass(400);
    chk("R4 started after counted edges", pass, 1);
    chk("R4 level stays zero", lvl, 0);
    chk("R4 no ramp in disabled mode", ract, 0);

    // R6 immediate stop
    ch_rst_n = 1'b0;
    step(1);
    chk("R6 hiz at once", hiz, 1);
    chk("R6 pass dropped at once", pass, 0);
    step(10);
    chk("R1 pass stays off with input toggling", pass, 0);

    // R9 idle restart of start count
    ch_rst_n = 1'b1;
    step(60);
    pwm_run = 1'b0;
    step(IT + 40);
    pwm_run = 1'b1;
    step(30 * 6);
    chk("R9 count restarted after idle", pass, 0);
    wait_pass(200);
    chk("R9 start after fresh count", pass, 1);
    ch_rst_n = 1'b0;
    step(5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule